// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one elementary NAND flash operation at a time for software. Software fills a command byte or an address byte through a small register file, chooses one of four buffer areas, and then starts the operation by writing a single trigger bit into the operation control register. The sequencer then drives the flash pins for one command cycle, one address cycle, a page data-in (buffer to flash), a page data-out (flash to buffer), an ID read or a status read. When the operation ends it sets a sticky completion flag, which also drives the interrupt output.

The internal byte buffer holds four main areas of `MAIN_B` bytes at the bottom. Four spare areas of `SPARE_B` bytes follow them. Software reaches the buffer through its own byte port. Page transfers move the main bytes of the chosen area and then its spare bytes. In spare-only mode they move the spare bytes alone. ID bytes always go to the start of the chosen main area. A status read writes a 16-bit word, with the status byte low and zero high, to the first word of the chosen main area. Before a data-out begins, the sequencer waits until the device reports ready.

Each flash strobe runs through three states: `S_SETUP` (`T_SU` clocks, data and latch enables driven), `S_PULSE` (`T_PW` clocks, the strobe low) and `S_HOLD` (`T_HD` clocks). The transitions are as follows:
- `S_IDLE` to `S_SETUP` on a valid trigger. A data-out goes to `S_WAIT_RDY` instead and moves to `S_SETUP` once the synchronised ready/busy line reads high.
- `S_HOLD` returns to `S_SETUP` for the next byte.
- After the last byte, `S_HOLD` goes to `S_STAT_HI` for a status read, where the zero high byte is written, and to `S_DONE` for every other operation.
- `S_DONE` returns to `S_IDLE` and sets the flag.

Top module: `nand_op_seq`

## Requirements
- R1: A synchronous active-high reset clears all registers (every register reads 0), clears the flag and `irq`, and drives `nf_ce_n`, `nf_we_n` and `nf_re_n` high, with `nf_cle`, `nf_ale` and `nf_dq_oe` low.
- R2: Writing 0x0001 to the operation control register (address 4) produces exactly one `nf_we_n` pulse with `nf_cle` high, `nf_ale` low and `nf_dq_out` equal to the low byte of the command register (address 0).
- R3: Writing 0x0002 to address 4 produces exactly one `nf_we_n` pulse with `nf_ale` high, `nf_cle` low and `nf_dq_out` equal to the low byte of the address register (address 1).
- R4: Bit 15 of address 4 is set when an operation completes. It stays set when software writes it as 1 and clears only when software writes address 4 with bit 15 at 0. `irq` mirrors it.
- R5: Trigger 0x0004 (data-in) with configuration bit 2 (address 3) clear sends main bytes 0 to 511 and then spare bytes 0 to 15 of the area chosen by address 2, one `nf_we_n` pulse per byte, with `nf_cle` and `nf_ale` low. Main area k starts at buffer byte 512·k, and spare area k starts at 2048+16·k.
- R6: Trigger 0x0008 (data-out) with bit 2 clear reads 528 bytes with `nf_re_n` pulses into main and then spare of the chosen area. Other areas are left unchanged.
- R7: With bit 2 set, a data-in or data-out moves only the 16 spare bytes of the chosen area, and the main area is left unchanged.
- R8: Trigger 0x0010 (ID read) reads `ID_BYTES` bytes into the chosen main area starting at offset 0, and leaves offset `ID_BYTES` unchanged.
- R9: Trigger 0x0020 (status read) reads one byte into offset 0 of the chosen main area and writes 0 to offset 1. Offset 2 is left unchanged.
- R10: While `nf_rb_n` is low, a data-out produces no `nf_re_n` pulse and does not set the flag. It completes after `nf_rb_n` goes high.
- R11: A trigger written while an operation runs is ignored, and so is a trigger value with zero or more than one of bits 5..0 set. Neither causes pin activity.
- R12: `nf_we_n` and `nf_re_n` are never low together, and each low pulse lasts exactly `T_PW` clocks.
- R13: When completion and a software write of 0 to bit 15 fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 command, 1 address, 2 area select, 3 configuration, 4 operation control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| buf_we | input | 1 | Software buffer write strobe |
| buf_addr | input | BUF_AW | Software buffer byte address |
| buf_wdata | input | 8 | Software buffer write byte |
| buf_rdata | output | 8 | Software buffer read byte, combinational |
| irq | output | 1 | Completion flag |
| nf_ce_n | output | 1 | Flash chip enable, low while an operation runs |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Flash write strobe |
| nf_re_n | output | 1 | Flash read strobe |
| nf_dq_out | output | 8 | Flash data bus, outgoing byte |
| nf_dq_oe | output | 1 | Output enable for the data bus |
| nf_dq_in | input | 8 | Flash data bus, incoming byte |
| nf_rb_n | input | 1 | Flash ready (high) / busy (low) |

## Verification
Two events can land in the same clock edge: the sequencer leaving `S_DONE` and setting the completion flag, and a software write to the operation control register that clears that flag. The bench provokes the clash by waiting for `nf_ce_n` to rise, which marks entry into `S_DONE`, and then placing a write of 0 to address 4 so that it is sampled at the very next edge. The flag must read 1 after that edge, and a later plain write of 0 must clear it.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    // operation code equals the index of its trigger bit
    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_DIN  = 3'd2,
        OP_DOUT = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_RDY,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_STAT_HI,
        S_DONE
    } state_e;

    localparam logic [2:0] REG_CMD   = 3'd0;
    localparam logic [2:0] REG_ADDR  = 3'd1;
    localparam logic [2:0] REG_SEL   = 3'd2;
    localparam logic [2:0] REG_CFG   = 3'd3;
    localparam logic [2:0] REG_OPCTL = 3'd4;

    localparam int TRIG_BITS = 6;
    localparam int FLAG_BIT  = 15;
    localparam int SPARE_BIT = 2;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int AREAS = 4,
    parameter int SELW  = $clog2(AREAS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [15:0]     reg_rdata,
    input  logic            busy_i,
    input  logic            done_i,
    output logic            start_o,
    output op_e             op_o,
    output logic [7:0]      cmd_o,
    output logic [7:0]      addr_o,
    output logic [SELW-1:0] sel_o,
    output logic            spare_o,
    output logic            flag_o
);

    logic [15:0]     cmd_q, addr_q;
    logic [SELW-1:0] sel_q;
    logic            spare_q, flag_q;
    logic            opctl_wr;
    logic [TRIG_BITS-1:0] trig;

    assign opctl_wr = reg_we && (reg_addr == REG_OPCTL);
    assign trig     = reg_wdata[TRIG_BITS-1:0];
    assign start_o  = opctl_wr && $onehot(trig) && !busy_i;

    always_comb begin
        op_o = OP_CMD;
        for (int b = 0; b < TRIG_BITS; b++) begin
            if (trig[b]) op_o = op_e'(3'(b));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            sel_q   <= '0;
            spare_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == REG_CMD)  cmd_q   <= reg_wdata;
            if (reg_we && reg_addr == REG_ADDR) addr_q  <= reg_wdata;
            if (reg_we && reg_addr == REG_SEL)  sel_q   <= reg_wdata[SELW-1:0];
            if (reg_we && reg_addr == REG_CFG)  spare_q <= reg_wdata[SPARE_BIT];
            // completion wins over a clearing write in the same cycle
            if (done_i)                                 flag_q <= 1'b1;
            else if (opctl_wr && !reg_wdata[FLAG_BIT])  flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CMD:   reg_rdata = cmd_q;
            REG_ADDR:  reg_rdata = addr_q;
            REG_SEL:   reg_rdata = 16'(sel_q);
            REG_CFG:   reg_rdata = 16'(spare_q) << SPARE_BIT;
            REG_OPCTL: reg_rdata = 16'(flag_q) << FLAG_BIT;
            default:   reg_rdata = '0;
        endcase
    end

    assign cmd_o   = cmd_q[7:0];
    assign addr_o  = addr_q[7:0];
    assign sel_o   = sel_q;
    assign spare_o = spare_q;
    assign flag_o  = flag_q;

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(opctl_wr && !reg_wdata[FLAG_BIT])) |=> flag_q);

    // R13
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |=> flag_q);

endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
    parameter int DEPTH = 2112,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    input  logic          en_we,
    input  logic [AW-1:0] en_addr,
    input  logic [7:0]    en_wdata,
    output logic [7:0]    en_rdata
);

    logic [7:0] mem [DEPTH];

    // the engine write is issued last so it wins on an address clash
    always_ff @(posedge clk) begin
        if (sw_we) mem[sw_addr] <= sw_wdata;
        if (en_we) mem[en_addr] <= en_wdata;
    end

    assign sw_rdata = mem[sw_addr];
    assign en_rdata = mem[en_addr];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int AREAS    = 4,
    parameter int MAIN_B   = 512,
    parameter int SPARE_B  = 16,
    parameter int ID_BYTES = 4,
    parameter int T_SU     = 2,
    parameter int T_PW     = 2,
    parameter int T_HD     = 1,
    parameter int SELW     = $clog2(AREAS),
    parameter int AW       = $clog2(AREAS*(MAIN_B+SPARE_B))
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  op_e             op_i,
    input  logic [7:0]      cmd_i,
    input  logic [7:0]      addr_i,
    input  logic [SELW-1:0] sel_i,
    input  logic            spare_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            buf_we_o,
    output logic [AW-1:0]   buf_addr_o,
    output logic [7:0]      buf_wdata_o,
    input  logic [7:0]      buf_rdata_i,
    output logic            nf_ce_n,
    output logic            nf_cle,
    output logic            nf_ale,
    output logic            nf_we_n,
    output logic            nf_re_n,
    output logic [7:0]      nf_dq_out,
    output logic            nf_dq_oe,
    input  logic [7:0]      nf_dq_in,
    input  logic            nf_rb_n
);

    localparam int SPARE_BASE = AREAS * MAIN_B;
    localparam int CW   = $clog2(MAIN_B + SPARE_B + 1);
    localparam int TMAX = (T_SU > T_PW) ? ((T_SU > T_HD) ? T_SU : T_HD)
                                        : ((T_PW > T_HD) ? T_PW : T_HD);
    localparam int TW   = $clog2(TMAX + 1);

    state_e          state_q;
    op_e             op_q;
    logic [7:0]      cmd_q, addr_q;
    logic [SELW-1:0] sel_q;
    logic            spare_q;
    logic [CW-1:0]   idx_q, last_q, last_d;
    logic [TW-1:0]   tcnt_q;
    logic            rdy_meta, rdy_s;
    logic            active, wr_op, xfer;

    always_comb begin
        unique case (op_i)
            OP_DIN, OP_DOUT: last_d = spare_i ? CW'(SPARE_B - 1) : CW'(MAIN_B + SPARE_B - 1);
            OP_ID:           last_d = CW'(ID_BYTES - 1);
            default:         last_d = '0;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            op_q     <= OP_CMD;
            cmd_q    <= '0;
            addr_q   <= '0;
            sel_q    <= '0;
            spare_q  <= 1'b0;
            idx_q    <= '0;
            last_q   <= '0;
            tcnt_q   <= '0;
            rdy_meta <= 1'b0;
            rdy_s    <= 1'b0;
        end else begin
            rdy_meta <= nf_rb_n;
            rdy_s    <= rdy_meta;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    op_q    <= op_i;
                    cmd_q   <= cmd_i;
                    addr_q  <= addr_i;
                    sel_q   <= sel_i;
                    spare_q <= spare_i;
                    idx_q   <= '0;
                    last_q  <= last_d;
                    tcnt_q  <= TW'(T_SU - 1);
                    state_q <= (op_i == OP_DOUT) ? S_WAIT_RDY : S_SETUP;
                end
                S_WAIT_RDY: if (rdy_s) begin
                    tcnt_q  <= TW'(T_SU - 1);
                    state_q <= S_SETUP;
                end
                S_SETUP: if (tcnt_q == '0) begin
                    tcnt_q  <= TW'(T_PW - 1);
                    state_q <= S_PULSE;
                end else tcnt_q <= tcnt_q - 1'b1;
                S_PULSE: if (tcnt_q == '0) begin
                    tcnt_q  <= TW'(T_HD - 1);
                    state_q <= S_HOLD;
                end else tcnt_q <= tcnt_q - 1'b1;
                S_HOLD: if (tcnt_q != '0) begin
                    tcnt_q <= tcnt_q - 1'b1;
                end else if (idx_q == last_q) begin
                    state_q <= (op_q == OP_STAT) ? S_STAT_HI : S_DONE;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    tcnt_q  <= TW'(T_SU - 1);
                    state_q <= S_SETUP;
                end
                S_STAT_HI: state_q <= S_DONE;
                S_DONE:    state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    assign active = (state_q == S_SETUP) || (state_q == S_PULSE) || (state_q == S_HOLD);
    assign wr_op  = (op_q == OP_CMD) || (op_q == OP_ADDR) || (op_q == OP_DIN);
    assign xfer   = (op_q == OP_DIN) || (op_q == OP_DOUT);

    // buffer address for the current byte
    always_comb begin
        int ib, mb, sb, a;
        ib = int'(idx_q);
        mb = int'(sel_q) * MAIN_B;
        sb = SPARE_BASE + int'(sel_q) * SPARE_B;
        if (state_q == S_STAT_HI)      a = mb + 1;
        else if (xfer && spare_q)      a = sb + ib;
        else if (xfer && ib >= MAIN_B) a = sb + ib - MAIN_B;
        else                           a = mb + ib;
        buf_addr_o = AW'(a);
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_DONE);
        nf_ce_n     = (state_q == S_IDLE) || (state_q == S_DONE);
        nf_cle      = active && (op_q == OP_CMD);
        nf_ale      = active && (op_q == OP_ADDR);
        nf_we_n     = !((state_q == S_PULSE) && wr_op);
        nf_re_n     = !((state_q == S_PULSE) && !wr_op);
        nf_dq_oe    = active && wr_op;
        nf_dq_out   = (op_q == OP_CMD)  ? cmd_q :
                      (op_q == OP_ADDR) ? addr_q : buf_rdata_i;
        buf_we_o    = ((state_q == S_PULSE) && !wr_op && (tcnt_q == '0))
                      || (state_q == S_STAT_HI);
        buf_wdata_o = (state_q == S_STAT_HI) ? 8'h00 : nf_dq_in;
    end

    // strobe low-run counter for the width check
    logic [TW:0] lowrun_q;
    always_ff @(posedge clk) begin
        if (rst || (nf_we_n && nf_re_n)) lowrun_q <= '0;
        else                             lowrun_q <= lowrun_q + 1'b1;
    end

    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (state_q == S_IDLE));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        nf_we_n || nf_re_n);

    // R12
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(nf_we_n) || $rose(nf_re_n)) |-> (lowrun_q == (TW+1)'(T_PW)));

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale) && (!nf_cle || !nf_ce_n));

    // R10
    wait_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT_RDY && !rdy_s) |=> nf_re_n);

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int AREAS    = 4,
    parameter int MAIN_B   = 512,
    parameter int SPARE_B  = 16,
    parameter int ID_BYTES = 4,
    parameter int T_SU     = 2,
    parameter int T_PW     = 2,
    parameter int T_HD     = 1,
    parameter int BUF_AW   = $clog2(AREAS*(MAIN_B+SPARE_B))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic              irq,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dq_out,
    output logic              nf_dq_oe,
    input  logic [7:0]        nf_dq_in,
    input  logic              nf_rb_n
);

    localparam int SELW  = $clog2(AREAS);
    localparam int DEPTH = AREAS * (MAIN_B + SPARE_B);

    logic            busy, done, start, spare;
    op_e             op;
    logic [7:0]      cmd_b, addr_b;
    logic [SELW-1:0] sel;
    logic            en_we;
    logic [BUF_AW-1:0] en_addr;
    logic [7:0]      en_wdata, en_rdata;

    nand_seq_regs #(.AREAS(AREAS), .SELW(SELW)) regs_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .done_i(done), .start_o(start), .op_o(op),
        .cmd_o(cmd_b), .addr_o(addr_b), .sel_o(sel), .spare_o(spare),
        .flag_o(irq)
    );

    nand_seq_buf #(.DEPTH(DEPTH), .AW(BUF_AW)) buf_i (
        .clk(clk),
        .sw_we(buf_we), .sw_addr(buf_addr), .sw_wdata(buf_wdata), .sw_rdata(buf_rdata),
        .en_we(en_we), .en_addr(en_addr), .en_wdata(en_wdata), .en_rdata(en_rdata)
    );

    nand_seq_fsm #(
        .AREAS(AREAS), .MAIN_B(MAIN_B), .SPARE_B(SPARE_B), .ID_BYTES(ID_BYTES),
        .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD), .SELW(SELW), .AW(BUF_AW)
    ) fsm_i (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op),
        .cmd_i(cmd_b), .addr_i(addr_b), .sel_i(sel), .spare_i(spare),
        .busy_o(busy), .done_o(done),
        .buf_we_o(en_we), .buf_addr_o(en_addr), .buf_wdata_o(en_wdata), .buf_rdata_i(en_rdata),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
        .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n)
    );

endmodule

// File: tb/nand_op_seq_tb_top.sv
module nand_op_seq_tb_top;

    localparam int MB = 512;
    localparam int SB = 16;
    localparam int SPB = 4 * MB;
    localparam int IDN = 4;
    localparam int TPW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        buf_we = 1'b0;
    logic [11:0] buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic [7:0]  buf_rdata;
    logic        irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_out;
    logic [7:0]  nf_dq_in = '0;
    logic        nf_rb_n = 1'b1;

    always #2.5 clk = ~clk;

    nand_op_seq dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .irq(irq), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // flash model: logs write strobes, answers read strobes
    int wr_cnt = 0, rd_cnt = 0, we_low = 0;
    logic [7:0] cap_dq  [1024];
    logic       cap_cle [1024];
    logic       cap_ale [1024];

    function automatic logic [7:0] fpat(int j);
        return 8'((j * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] gpat(int a);
        return 8'(((a * 13 + 5) ^ (a >> 8)) & 255);
    endfunction

    always @(posedge nf_we_n) begin
        if (wr_cnt < 1024) begin
            cap_dq[wr_cnt]  = nf_dq_out;
            cap_cle[wr_cnt] = nf_cle;
            cap_ale[wr_cnt] = nf_ale;
        end
        wr_cnt++;
    end
    always @(negedge nf_re_n) begin
        nf_dq_in = fpat(rd_cnt);
        rd_cnt++;
    end
    always @(negedge clk) if (nf_we_n === 1'b0) we_low++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask
    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask
    task automatic buf_w(input int a, input logic [7:0] d);
        @(negedge clk); buf_we = 1'b1; buf_addr = 12'(a); buf_wdata = d;
        @(negedge clk); buf_we = 1'b0;
    endtask
    task automatic buf_r(input int a, output logic [7:0] d);
        @(negedge clk); buf_addr = 12'(a); #1 d = buf_rdata;
    endtask
    task automatic wait_flag(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask
    task automatic clr_log();
        wr_cnt = 0; rd_cnt = 0; we_low = 0;
    endtask

    // command / address vectors: {is_addr, register value, expected bus byte}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 16'h0000, 8'h00},
        {1'b0, 16'h0090, 8'h90},
        {1'b1, 16'h005A, 8'h5A},
        {1'b1, 16'h12FF, 8'hFF},
        {1'b0, 16'hAB70, 8'h70},
        {1'b1, 16'h0100, 8'h00}
    };

    initial begin
        logic [15:0] r;
        logic [7:0]  b;
        int bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), r);
            check(r == 16'h0, "R1 register reset", r, 0);
        end
        check(irq == 1'b0 && nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle", {irq, nf_ce_n, nf_we_n, nf_re_n}, 4'b0111);
        check(!nf_cle && !nf_ale && !nf_dq_oe, "R1 latches low", {nf_cle, nf_ale, nf_dq_oe}, 0);

        // R2 / R3 vector walk
        for (int k = 0; k < 6; k++) begin
            bit isa;
            isa = VEC[k][24];
            wr_reg(isa ? 3'd1 : 3'd0, VEC[k][23:8]);
            clr_log();
            wr_reg(3'd4, isa ? 16'h0002 : 16'h0001);
            wait_flag(100);
            check(irq == 1'b1, isa ? "R3 flag" : "R2 flag", irq, 1);
            check(wr_cnt == 1, isa ? "R3 pulse count" : "R2 pulse count", wr_cnt, 1);
            check(cap_dq[0] == VEC[k][7:0], isa ? "R3 bus byte" : "R2 bus byte", cap_dq[0], VEC[k][7:0]);
            check(cap_cle[0] == !isa && cap_ale[0] == isa, isa ? "R3 latch" : "R2 latch",
                  {cap_cle[0], cap_ale[0]}, {!isa, isa});
            check(we_low == TPW, "R12 pulse width", we_low, TPW);
            wr_reg(3'd4, 16'h0000);
        end

        // R4 sticky flag
        wr_reg(3'd4, 16'h0001);
        wait_flag(100);
        wr_reg(3'd4, 16'h8000);
        rd_reg(3'd4, r);
        check(r[15] && irq, "R4 write 1 keeps flag", r, 16'h8000);
        repeat (5) @(negedge clk);
        rd_reg(3'd4, r);
        check(r[15], "R4 flag stays", r, 16'h8000);
        wr_reg(3'd4, 16'h0000);
        rd_reg(3'd4, r);
        check(!r[15] && !irq, "R4 write 0 clears", r, 0);

        // R13 completion and clear in the same cycle
        wr_reg(3'd4, 16'h0001);
        @(posedge nf_ce_n);
        wr_reg(3'd4, 16'h0000);
        rd_reg(3'd4, r);
        check(r[15], "R13 set wins", r, 16'h8000);
        wr_reg(3'd4, 16'h0000);

        // R5 full data-in from area 2
        for (int a = 0; a < MB + SB; a++) begin
            int ad;
            ad = (a < MB) ? 2 * MB + a : SPB + 2 * SB + (a - MB);
            buf_w(ad, gpat(ad));
        end
        wr_reg(3'd2, 16'd2);
        wr_reg(3'd3, 16'h0000);
        clr_log();
        wr_reg(3'd4, 16'h0004);
        wait_flag(6000);
        check(wr_cnt == MB + SB, "R5 byte count", wr_cnt, MB + SB);
        bad = 0;
        for (int a = 0; a < MB + SB; a++) begin
            int ad;
            ad = (a < MB) ? 2 * MB + a : SPB + 2 * SB + (a - MB);
            if (cap_dq[a] !== gpat(ad) || cap_cle[a] || cap_ale[a]) bad++;
        end
        check(bad == 0, "R5 byte order", bad, 0);
        wr_reg(3'd4, 16'h0000);

        // R10 + R6 full data-out into area 1 behind busy
        nf_rb_n = 1'b0;
        wr_reg(3'd2, 16'd1);
        clr_log();
        wr_reg(3'd4, 16'h0008);
        repeat (40) @(negedge clk);
        check(rd_cnt == 0 && irq == 0, "R10 held while busy", rd_cnt, 0);
        nf_rb_n = 1'b1;
        wait_flag(6000);
        check(irq == 1'b1 && rd_cnt == MB + SB, "R10 completes after ready", rd_cnt, MB + SB);
        bad = 0;
        for (int a = 0; a < MB + SB; a++) begin
            buf_r((a < MB) ? MB + a : SPB + SB + (a - MB), b);
            if (b !== fpat(a)) bad++;
        end
        check(bad == 0, "R6 buffer contents", bad, 0);
        buf_r(2 * MB + 7, b);
        check(b == gpat(2 * MB + 7), "R6 other area intact", b, gpat(2 * MB + 7));
        wr_reg(3'd4, 16'h0000);

        // R7 spare-only data-out into area 3
        buf_w(3 * MB, 8'hA5);
        buf_w(3 * MB + MB - 1, 8'h5A);
        wr_reg(3'd2, 16'd3);
        wr_reg(3'd3, 16'h0004);
        clr_log();
        wr_reg(3'd4, 16'h0008);
        wait_flag(1000);
        check(rd_cnt == SB, "R7 spare count", rd_cnt, SB);
        bad = 0;
        for (int a = 0; a < SB; a++) begin
            buf_r(SPB + 3 * SB + a, b);
            if (b !== fpat(a)) bad++;
        end
        check(bad == 0, "R7 spare contents", bad, 0);
        buf_r(3 * MB, b);
        check(b == 8'hA5, "R7 main untouched", b, 8'hA5);
        buf_r(3 * MB + MB - 1, b);
        check(b == 8'h5A, "R7 main end untouched", b, 8'h5A);
        wr_reg(3'd4, 16'h0000);

        // R11 trigger during an operation, then a two-bit trigger
        wr_reg(3'd2, 16'd0);
        clr_log();
        wr_reg(3'd4, 16'h0004);
        wr_reg(3'd4, 16'h0001);
        wait_flag(1000);
        check(wr_cnt == SB, "R11 busy trigger ignored count", wr_cnt, SB);
        bad = 0;
        for (int a = 0; a < SB; a++) if (cap_cle[a]) bad++;
        check(bad == 0, "R11 no command cycle", bad, 0);
        wr_reg(3'd4, 16'h0000);
        clr_log();
        wr_reg(3'd4, 16'h0003);
        repeat (30) @(negedge clk);
        check(wr_cnt == 0 && rd_cnt == 0 && irq == 0 && nf_ce_n, "R11 multi-bit ignored", wr_cnt + rd_cnt, 0);
        wr_reg(3'd3, 16'h0000);

        // R8 ID read into area 2
        wr_reg(3'd2, 16'd2);
        clr_log();
        wr_reg(3'd4, 16'h0010);
        wait_flag(200);
        check(rd_cnt == IDN, "R8 id count", rd_cnt, IDN);
        bad = 0;
        for (int a = 0; a < IDN; a++) begin
            buf_r(2 * MB + a, b);
            if (b !== fpat(a)) bad++;
        end
        check(bad == 0, "R8 id bytes", bad, 0);
        buf_r(2 * MB + IDN, b);
        check(b == gpat(2 * MB + IDN), "R8 next byte untouched", b, gpat(2 * MB + IDN));
        wr_reg(3'd4, 16'h0000);

        // R9 status read into area 1
        wr_reg(3'd2, 16'd1);
        clr_log();
        wr_reg(3'd4, 16'h0020);
        wait_flag(200);
        buf_r(MB, b);
        check(b == fpat(0), "R9 status low byte", b, fpat(0));
        buf_r(MB + 1, b);
        check(b == 8'h00, "R9 status high byte", b, 0);
        buf_r(MB + 2, b);
        check(b == fpat(2), "R9 rest untouched", b, fpat(2));
        wr_reg(3'd4, 16'h0000);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule